// File: doc/BRIEF.md
# Byte-Serial Frame Sender

This block lets a host whose serial port moves only 8-bit bytes, least significant bit first, send a 24-bit command to a receiver that expects the word most significant bit first. A command word comes in over a valid/ready handshake. The block drives its own frame-select line low. It then sends the word as three bytes through an internal LSB-first byte shifter. Each byte is bit-mirrored before it is loaded, so the receiver sees bits 23 down to 0 in that order.

The serial clock idles high. Its half-period is `HALF` system clock cycles. Data changes on the rising edge of the serial clock, so the receiver samples it on the falling edge. Frame-select stays low across the idle gaps between bytes. It returns high only after the third byte has finished. A one-cycle `done` pulse follows.

Back-pressure: `cmd_ready` is high only while the block is idle. A word transfers on a cycle where both `cmd_valid` and `cmd_ready` are high. While a frame is in flight, `cmd_ready` is low, and a `cmd_valid` raised in that time is dropped: it is not queued. The source must therefore present its next word after `done`.

Top module: `byte_frame_tx`

## Requirements
- R1: After reset and while idle: `fsel_n`=1, `sclk`=1, `busy`=0, `done`=0 and `cmd_ready`=1.
- R2: In the cycle after a handshake (`cmd_valid` and `cmd_ready` both high at a clock edge), `fsel_n` is 0 and `busy` is 1. At least `HALF` cycles with `fsel_n` low pass before the first falling edge of `sclk`.
- R3: Over one frame, the bits on `sdata` at the 24 falling edges of `sclk` are `cmd_word` bits 23, 22, … 0, in that order. So bits 23:16 go first, then 15:8, then 7:0, each byte MSB first.
- R4: A frame has exactly 24 falling edges of `sclk`, in three groups of 8. `sclk` never falls while `fsel_n` is 1.
- R5: `sdata` changes only when `sclk` rises or while `sclk` is high. It holds its value across every falling edge.
- R6: Inside a byte, `sclk` is low for exactly `HALF` cycles per bit, and high for exactly `HALF` cycles between consecutive bits.
- R7: Between two bytes of a frame, `sclk` stays high for at least `2*HALF` cycles while `fsel_n` stays low.
- R8: `fsel_n` rises only after the 24th falling edge, with `sclk` already high.
- R9: `done` is high for exactly one cycle: the second cycle in which `fsel_n` is high after a frame. In the cycle after `done`, `busy`=0 and `cmd_ready`=1.
- R10: `cmd_ready` is 0 while `busy` is 1. A `cmd_valid` pulse given during that time produces no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_word | input | 24 | Command word to send |
| fsel_n | output | 1 | Frame-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, stable at falling sclk edges |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after a frame ends |

## Verification
Words with a lone top bit (0x800000) and a lone bottom bit (0x000001) show whether the byte order and the per-byte mirroring are correct. The word 0x123456, with a distinct value in each byte, shows whether bytes are swapped. All-ones and all-zeros words expose a stuck data line. They also check the edge count and gap timing with no data transitions present. The pattern 0xA5C3F0 toggles often within a byte and between bytes. A frame started while another is in flight shows whether a command offered while busy is dropped or leaks out as an extra frame.

// File: rtl/bft_pkg.sv
package bft_pkg;
  typedef enum logic [1:0] {
    SH_IDLE,
    SH_SETUP,
    SH_LOW,
    SH_HIGH
  } sh_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_SEND,
    SQ_GAP,
    SQ_TAIL,
    SQ_REL,
    SQ_FIN
  } sq_state_t;
endpackage

// File: rtl/bft_mirror.sv
module bft_mirror #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/bft_shifter.sv
// LSB-first byte engine: HALF cycles of setup with sclk high, then
// W bits, each HALF low then HALF high; data shifts on the rising edge.
module bft_shifter
  import bft_pkg::*;
#(
  parameter int HALF = 2,
  parameter int W    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sclk,
  output logic         sdata,
  output logic         byte_done
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  sh_state_t      st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitn;
  logic [W-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SH_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      unique case (st)
        SH_IDLE: begin
          if (load) begin
            shreg <= din;
            cnt   <= '0;
            bitn  <= '0;
            st    <= SH_SETUP;
          end
        end
        SH_SETUP: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            st  <= SH_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SH_LOW: begin
          if (cnt == HALF_END) begin
            cnt   <= '0;
            shreg <= {1'b0, shreg[W-1:1]};
            if (bitn == LAST_BIT) begin
              st        <= SH_IDLE;
              byte_done <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              st   <= SH_HIGH;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SH_HIGH: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            st  <= SH_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign sclk  = (st != SH_LOW);
  assign sdata = shreg[0];
endmodule

// File: rtl/byte_frame_tx.sv
module byte_frame_tx
  import bft_pkg::*;
#(
  parameter int HALF   = 2,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              fsel_n,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              done
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int GAP    = 2 * HALF;
  localparam int CW     = $clog2(GAP + 1);
  localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(GAP - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

  sq_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] word_q;
  logic              fsel_q;
  logic              load;
  logic              byte_done;
  logic [BYTE_W-1:0] raw_byte;
  logic [BYTE_W-1:0] mir_byte;

  assign raw_byte = word_q[WORD_W-1 -: BYTE_W];
  assign load = ((st == SQ_LEAD) && (cnt == HALF_END)) ||
                ((st == SQ_GAP)  && (cnt == GAP_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      idx    <= '0;
      word_q <= '0;
      fsel_q <= 1'b1;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (cmd_valid) begin
            word_q <= cmd_word;
            fsel_q <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            st     <= SQ_LEAD;
          end
        end
        SQ_LEAD: begin
          if (load) begin
            word_q <= word_q << BYTE_W;
            st     <= SQ_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_SEND: begin
          if (byte_done) begin
            cnt <= '0;
            if (idx == LAST_IDX) begin
              st <= SQ_TAIL;
            end else begin
              idx <= idx + 1'b1;
              st  <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (load) begin
            word_q <= word_q << BYTE_W;
            st     <= SQ_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_TAIL: begin
          if (cnt == HALF_END) begin
            fsel_q <= 1'b1;
            st     <= SQ_REL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_REL:  st <= SQ_FIN;
        SQ_FIN:  st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  bft_mirror #(.W(BYTE_W)) u_mirror (
    .din  (raw_byte),
    .dout (mir_byte)
  );

  bft_shifter #(.HALF(HALF), .W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .din       (mir_byte),
    .sclk      (sclk),
    .sdata     (sdata),
    .byte_done (byte_done)
  );

  assign cmd_ready = (st == SQ_IDLE);
  assign busy      = (st != SQ_IDLE);
  assign done      = (st == SQ_FIN);
  assign fsel_n    = fsel_q;
endmodule

// File: rtl/byte_frame_tx_chk.sv
module byte_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic fsel_n,
  input logic sclk,
  input logic sdata,
  input logic busy,
  input logic done
);
  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!fsel_n && busy));
  // R4
  no_clock_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_n |-> sclk);
  // R5
  data_stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdata));
  // R8
  release_high_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsel_n) |-> sclk);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fsel_n && $past(fsel_n)));
  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

bind byte_frame_tx byte_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .fsel_n    (fsel_n),
  .sclk      (sclk),
  .sdata     (sdata),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_byte_frame_tx.sv
`timescale 1ns/1ps
module sim_byte_frame_tx;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic        cmd_ready, fsel_n, sclk, sdata, busy, done;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  int frames_exp = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  byte_frame_tx #(.HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .fsel_n(fsel_n), .sclk(sclk), .sdata(sdata),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: offers a word and pushes the expected bit stream
  task automatic send(input logic [23:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    for (int i = 23; i >= 0; i--) exp_q.push_back(w[i]);
    frames_exp++;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!fsel_n && busy, "R2 accept", {30'd0, fsel_n, busy}, 1);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  // monitor
  logic p_sclk = 1'b1, p_fsel = 1'b1, p2_fsel = 1'b1, p_sdata = 1'b0, p_done = 1'b0;
  int high_run = 0, low_run = 0, lead = 0, edges = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_sclk && !sclk) begin
        if (fsel_n) begin
          chk(1'b0, "R4 sclk fell with fsel_n high", 1, 0);
        end else begin
          edges++;
          chk(sdata == p_sdata, "R5 data moved at fall", sdata, p_sdata);
          if (edges == 1)
            chk(lead >= HALF, "R2 lead time", lead, HALF);
          else if ((edges - 1) % 8 == 0)
            chk(high_run >= 2 * HALF, "R7 inter-byte gap", high_run, 2 * HALF);
          else
            chk(high_run == HALF, "R6 high half-period", high_run, HALF);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected bit", edges, 0);
          end else begin
            bit e;
            e = exp_q.pop_front();
            chk(sdata == e, "R3 bit order", sdata, e);
          end
        end
      end
      if (!p_sclk && sclk && !fsel_n)
        chk(low_run == HALF, "R6 low half-period", low_run, HALF);
      if (p_fsel && !fsel_n) begin
        edges = 0;
        lead  = 0;
        chk(busy == 1'b1, "R2 busy in frame", busy, 1);
      end
      if (!p_fsel && fsel_n) begin
        frames++;
        chk(edges == 24, "R4 R8 edges before release", edges, 24);
        chk(sclk == 1'b1, "R8 sclk high at release", sclk, 1);
      end
      if (done)
        chk(fsel_n && p_fsel && !p2_fsel, "R9 done timing",
            {29'd0, fsel_n, p_fsel, p2_fsel}, 6);
      if (p_done)
        chk(!busy && cmd_ready && !done, "R9 after done",
            {29'd0, busy, cmd_ready, done}, 2);
      high_run = sclk ? (p_sclk ? high_run + 1 : 1) : 0;
      low_run  = !sclk ? (!p_sclk ? low_run + 1 : 1) : 0;
      if (!fsel_n && edges == 0) lead++;
      p2_fsel = p_fsel;
      p_fsel  = fsel_n;
      p_sclk  = sclk;
      p_sdata = sdata;
      p_done  = done;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fsel_n && sclk && !busy && !done && cmd_ready, "R1 reset state",
        {27'd0, fsel_n, sclk, busy, done, cmd_ready}, 25);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(fsel_n && sclk && !busy && !done && cmd_ready, "R1 idle state",
        {27'd0, fsel_n, sclk, busy, done, cmd_ready}, 25);

    send(24'h800000); wait_done();
    send(24'h000001); wait_done();
    send(24'h123456); wait_done();
    send(24'hFFFFFF); wait_done();
    send(24'h000000); wait_done();
    send(24'hA5C3F0); wait_done();

    // R10: offer a word mid-frame
    send(24'h3C5A96);
    repeat (20) @(negedge clk);
    chk(cmd_ready == 1'b0, "R10 ready low while busy", cmd_ready, 0);
    cmd_word  = 24'hFFFF00;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (200) @(negedge clk);
    chk(fsel_n == 1'b1, "R10 no extra frame", fsel_n, 1);
    chk(frames == frames_exp, "R10 frame count", frames, frames_exp);
    chk(exp_q.size() == 0, "R3 all bits sent", exp_q.size(), 0);

    // R1 back in idle
    chk(fsel_n && sclk && !busy && !done && cmd_ready, "R1 idle after frames",
        {27'd0, fsel_n, sclk, busy, done, cmd_ready}, 25);
    summary();
    $finish;
  end
endmodule